// File: doc/BRIEF.md
# Return Address Stack with Fault Reset

This block holds return addresses for a small processor core. On a call or on entry to an interrupt the core asserts `push` together with the return address. The stack keeps that address as its new top entry. On a return the core asserts `pop`, and the entry below the old top comes up to the `tos` output. The top of stack is held in a register, so `tos` is valid one cycle after each operation. While the stack is empty, `tos` reads zero.

Two errors are detected:
- An overflow is a push while all entries are in use.
- An underflow is a pop while no entries are in use.

Each error sets its own sticky flag. The flag stays set until software pulses `flag_clr` or the power-on reset `rst` is applied. The configuration input `fault_rst_en` selects whether an error also raises a one-cycle `reset_req` pulse for the reset controller, or only sets its flag. Program counter logic, instruction decode and the reset controller are outside this block.

Top module: `ret_addr_stack`

## Requirements
- R1: A push on a stack that is not full makes `push_addr` the value of `tos` in the next cycle and adds one entry.
- R2: A pop on a non-empty stack removes the top entry. In the next cycle `tos` shows the entry that was below it, or zero if the stack is now empty.
- R3: A push on a full stack (DEPTH entries, default 31) sets `ovf_flag`. It stores nothing, does not move the pointer and leaves `tos` unchanged.
- R4: A pop on an empty stack sets `unf_flag`, leaves the pointer at zero and keeps `tos` at zero.
- R5: When `fault_rst_en` is 1 during an overflowing or underflowing operation, `reset_req` is 1 for exactly the one cycle that follows that operation.
- R6: When `fault_rst_en` is 0, overflow and underflow still set their flags, but `reset_req` stays 0.
- R7: `ovf_flag` and `unf_flag` stay set until `flag_clr` is 1 at a clock edge or `rst` is applied. If an error occurs in the same cycle as `flag_clr`, setting the flag takes priority over clearing it.
- R8: `push` and `pop` in the same cycle act as a pop followed by a push. On a non-empty stack (full included) the top entry is replaced by `push_addr` and the depth is unchanged. On an empty stack the cycle counts as an underflow, and the address is then stored as the only entry.
- R9: A synchronous `rst` empties the stack and clears `tos`, both flags and `reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| push | input | 1 | Push strobe (call or interrupt entry) |
| pop | input | 1 | Pop strobe (return) |
| push_addr | input | AW (21) | Return address to store |
| fault_rst_en | input | 1 | 1: overflow/underflow also request a device reset |
| flag_clr | input | 1 | Software clear of both sticky flags |
| tos | output | AW (21) | Current top entry, zero when empty |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| reset_req | output | 1 | One-cycle device reset request |

## Verification
The hardest state to reach from the ports is the boundary at full depth. The bench has to issue 31 pushes with distinct addresses before any overflow can occur. It then tries extra pushes and a simultaneous push and pop at that depth. Finally it pops the whole stack, to show that the refused push overwrote nothing and that the swap replaced only the top entry. Flag priority is tested by applying `flag_clr` in the same cycle as a new error. A random phase then mixes all strobes near both ends of the stack.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int RAS_DEPTH_DEF = 31;
  localparam int RAS_AW_DEF    = 21;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_SWAP = 2'b11
  } ras_op_e;
endpackage

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [AW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  input  logic [AW-1:0] below_data,
  output logic          we,
  output logic [IW-1:0] waddr,
  output logic [IW-1:0] raddr,
  output logic [AW-1:0] tos,
  output logic [PW-1:0] lvl,
  output logic          ovf_evt,
  output logic          unf_evt
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  ras_op_e       op;
  logic [PW-1:0] lvl_n, lvl_m1, lvl_m2;
  logic [AW-1:0] tos_n;
  logic          empty, full;

  assign op     = ras_op_e'({push, pop});
  assign empty  = (lvl == '0);
  assign full   = (lvl == FULL_LVL);
  assign lvl_m1 = lvl - PW'(1);
  assign lvl_m2 = lvl - PW'(2);
  assign raddr  = lvl_m2[IW-1:0];

  always_comb begin
    we      = 1'b0;
    waddr   = lvl[IW-1:0];
    lvl_n   = lvl;
    tos_n   = tos;
    ovf_evt = 1'b0;
    unf_evt = 1'b0;
    unique case (op)
      OP_PUSH: begin
        if (full) begin
          ovf_evt = 1'b1;
        end else begin
          we    = 1'b1;
          lvl_n = lvl + PW'(1);
          tos_n = push_addr;
        end
      end
      OP_POP: begin
        if (empty) begin
          unf_evt = 1'b1;
        end else begin
          lvl_n = lvl_m1;
          tos_n = (lvl >= PW'(2)) ? below_data : '0;
        end
      end
      OP_SWAP: begin
        we    = 1'b1;
        tos_n = push_addr;
        if (empty) begin
          unf_evt = 1'b1;
          waddr   = '0;
          lvl_n   = PW'(1);
        end else begin
          waddr = lvl_m1[IW-1:0];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= '0;
      tos <= '0;
    end else begin
      lvl <= lvl_n;
      tos <= tos_n;
    end
  end
endmodule

// File: rtl/ras_fault.sv
module ras_fault (
  input  logic clk,
  input  logic rst,
  input  logic ovf_evt,
  input  logic unf_evt,
  input  logic fault_rst_en,
  input  logic flag_clr,
  output logic ovf_flag,
  output logic unf_flag,
  output logic reset_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag  <= 1'b0;
      unf_flag  <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      ovf_flag  <= ovf_evt | (ovf_flag & ~flag_clr);
      unf_flag  <= unf_evt | (unf_flag & ~flag_clr);
      reset_req <= fault_rst_en & (ovf_evt | unf_evt);
    end
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int DEPTH = RAS_DEPTH_DEF,
  parameter int AW    = RAS_AW_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  input  logic          fault_rst_en,
  input  logic          flag_clr,
  output logic [AW-1:0] tos,
  output logic          ovf_flag,
  output logic          unf_flag,
  output logic          reset_req
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = $clog2(DEPTH + 1);

  logic          we, ovf_evt, unf_evt;
  logic [IW-1:0] waddr, raddr;
  logic [AW-1:0] below_data;
  logic [PW-1:0] lvl;

  ras_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .push_addr(push_addr),
    .below_data(below_data), .we(we), .waddr(waddr), .raddr(raddr),
    .tos(tos), .lvl(lvl), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(push_addr),
    .raddr(raddr), .rdata(below_data)
  );

  ras_fault u_fault (
    .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .fault_rst_en(fault_rst_en), .flag_clr(flag_clr),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .reset_req(reset_req)
  );
endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          push,
  input logic          pop,
  input logic [AW-1:0] push_addr,
  input logic          fault_rst_en,
  input logic          flag_clr,
  input logic [AW-1:0] tos,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          reset_req,
  input logic [PW-1:0] lvl
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  assert_push_top_R1: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && lvl != FULL_LVL) |=> (tos == $past(push_addr)));

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
    lvl <= FULL_LVL);

  assert_empty_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (lvl == '0) |-> (tos == '0));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && lvl == FULL_LVL) |=> (ovf_flag && $stable(lvl) && $stable(tos)));

  assert_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && lvl == '0) |=> (unf_flag && lvl == '0));

  assert_req_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_req) |-> ($past(fault_rst_en) && ($rose(ovf_flag) || $rose(unf_flag)
                                                  || $past(ovf_flag || unf_flag))));

  assert_req_off_R6: assert property (@(posedge clk) disable iff (rst)
    !fault_rst_en |=> !reset_req);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (unf_flag && !flag_clr) |=> unf_flag);

  assert_swap_R8: assert property (@(posedge clk) disable iff (rst)
    (push && pop && lvl != '0) |=> (tos == $past(push_addr) && $stable(lvl)));
endmodule

bind ret_addr_stack ret_addr_stack_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .push(push), .pop(pop), .push_addr(push_addr),
  .fault_rst_en(fault_rst_en), .flag_clr(flag_clr), .tos(tos),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag), .reset_req(reset_req), .lvl(lvl)
);

// File: tb/tb_ret_addr_stack.sv
`timescale 1ns/1ps
module tb_ret_addr_stack;
  localparam int DEPTH = 31;
  localparam int AW    = 21;

  logic          clk = 1'b0;
  logic          rst, push, pop, fault_rst_en, flag_clr;
  logic [AW-1:0] push_addr;
  logic [AW-1:0] tos;
  logic          ovf_flag, unf_flag, reset_req;

  ret_addr_stack #(.DEPTH(DEPTH), .AW(AW)) dut (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .push_addr(push_addr),
    .fault_rst_en(fault_rst_en), .flag_clr(flag_clr), .tos(tos),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .reset_req(reset_req)
  );

  initial forever #4 clk = ~clk;

  int            n_vec = 0, n_bad = 0;
  bit            finished = 0;
  logic [AW-1:0] q[$];
  logic          m_ovf, m_unf, m_req;
  logic [AW-1:0] m_tos;

  task automatic compare(string tag);
    n_vec++;
    if (tos !== m_tos) begin
      n_bad++; $display("FAIL %s tos actual=%h expected=%h", tag, tos, m_tos);
    end
    if (ovf_flag !== m_ovf) begin
      n_bad++; $display("FAIL %s ovf_flag actual=%b expected=%b", tag, ovf_flag, m_ovf);
    end
    if (unf_flag !== m_unf) begin
      n_bad++; $display("FAIL %s unf_flag actual=%b expected=%b", tag, unf_flag, m_unf);
    end
    if (reset_req !== m_req) begin
      n_bad++; $display("FAIL %s reset_req actual=%b expected=%b", tag, reset_req, m_req);
    end
  endtask

  task automatic do_reset(string tag);
    rst = 1'b1; push = 0; pop = 0; flag_clr = 0; push_addr = '0;
    @(posedge clk);
    q.delete(); m_ovf = 0; m_unf = 0; m_req = 0; m_tos = '0;
    @(negedge clk);
    rst = 1'b0;
    compare(tag);
  endtask

  task automatic step(bit ps, bit pp, logic [AW-1:0] d, bit en, bit clr, string tag);
    bit so, su;
    push = ps; pop = pp; push_addr = d; fault_rst_en = en; flag_clr = clr;
    @(posedge clk);
    so = 0; su = 0;
    if (ps && pp) begin
      if (q.size() == 0) begin su = 1; q.push_back(d); end
      else q[q.size()-1] = d;
    end else if (ps) begin
      if (q.size() == DEPTH) so = 1; else q.push_back(d);
    end else if (pp) begin
      if (q.size() == 0) su = 1; else void'(q.pop_back());
    end
    m_ovf = so | (m_ovf & ~clr);
    m_unf = su | (m_unf & ~clr);
    m_req = en & (so | su);
    m_tos = (q.size() == 0) ? '0 : q[q.size()-1];
    @(negedge clk);
    push = 0; pop = 0; flag_clr = 0;
    compare(tag);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    fault_rst_en = 0;
    @(negedge clk);
    do_reset("R9 reset state");
    // R1 / R2: basic push then pop
    for (int i = 0; i < 5; i++) step(1, 0, AW'(21'h1000 + i * 3), 0, 0, "R1 push");
    for (int i = 0; i < 6; i++) step(0, 1, '0, 0, 0, "R2 pop");
    // R4 / R6: underflow without reset request (the sixth pop above also underflowed)
    step(0, 1, '0, 0, 0, "R4 R6 underflow no request");
    step(0, 0, '0, 0, 0, "R7 flag held");
    step(0, 0, '0, 0, 1, "R7 clear");
    // R5: underflow with reset request, then one-cycle pulse
    step(0, 1, '0, 1, 0, "R5 underflow request");
    step(0, 0, '0, 1, 0, "R5 pulse ends");
    // R7: clear in same cycle as new fault keeps flag
    step(0, 1, '0, 0, 1, "R7 set beats clear");
    step(0, 0, '0, 0, 1, "R7 clear");
    // R3: fill to full then overflow
    for (int i = 0; i < DEPTH; i++) step(1, 0, AW'(21'h0A000 + i * 7), 0, 0, "R1 fill");
    step(1, 0, 21'h1FFFFF, 1, 0, "R3 R5 overflow request");
    step(1, 0, 21'h155555, 0, 0, "R3 R6 overflow no request");
    step(1, 1, 21'h0ABCDE, 0, 1, "R8 swap at full");
    step(1, 0, 21'h012345, 0, 0, "R3 still full");
    for (int i = 0; i < DEPTH + 1; i++) step(0, 1, '0, 0, 0, "R2 R3 drain");
    // R8: swap on empty
    step(0, 0, '0, 0, 1, "R7 clear");
    step(1, 1, 21'h0BEEF0, 1, 0, "R8 swap on empty");
    step(1, 1, 21'h0CAFE1, 1, 0, "R8 swap replaces");
    step(1, 0, 21'h000042, 0, 0, "R1 push after swap");
    step(0, 1, '0, 0, 0, "R8 R2 pop to swapped");
    // R9: reset mid-stream
    step(0, 1, 21'h0, 1, 0, "R2 pop");
    do_reset("R9 reset clears");
    // random mix
    for (int i = 0; i < 600; i++) begin
      bit ps = ($urandom % 100) < 55;
      bit pp = ($urandom % 100) < 45;
      step(ps, pp, AW'($urandom), 1'($urandom), ($urandom % 10) == 0, "R1 R2 R3 R4 R8 random");
    end
    finished = 1;
    summary();
  end
endmodule